// File: doc/BRIEF.md
# Clustered Hit Frame Formatter

The formatter sits between the triggered-hit readout of a pixel matrix and the output line encoder. Hits arrive one per handshake as a column address, a row address and a 4-bit time-over-threshold value. Within each column they come in ascending row order, and the final hit of an event carries an end-of-event flag. The formatter packs hits that lie close together along the row direction into fixed-size frames. Each frame is right-aligned in a 26-bit output word and leaves on a valid/ready stream, with a 2-bit tag that gives its format.

Four formats are available, chosen by a 2-bit configuration input:

| Code | Format | Frame width |
|------|--------|-------------|
| 0 | one pixel with its ToT | 22 bits |
| 1 | a row pair with two ToT slots | 26 bits |
| 2 | a row pair with hit flags only | 20 bits |
| 3 | a four-row group with hit flags only | 24 bits |

A frame's start row is always the row of the hit that opened it, not a fixed alignment. The formatter holds at most one frame under construction. That frame is emitted when a hit falls outside its span, when the column changes, or when the event ends.

Top module: `cluster_frame_fmt`

## Requirements
- R1: After reset, with out_ready high, out_valid is low and hit_ready is high.
- R2: In format 0 every accepted hit gives one frame. The frame is col<<15 | row<<6 | tot<<2, and bits 25..22 of the word are zero.
- R3: In format 1 a hit opens a frame whose start row is its own row. The next hit is merged into the second slot when it has the same column and row start+1. The frame is col<<19 | row<<10 | t0<<6 | t1<<2, and an empty slot carries 4'hF.
- R4: In format 2 the frame is col<<13 | row<<4 | h0<<3 | h1<<2, where hN is 1 when slot N holds a hit. Bits 25..20 are zero.
- R5: In format 3 hits at rows start+1 to start+3 of the same column share one frame, and a hit at row start+4 or beyond opens a new one. The frame is col<<17 | row<<8 | h0<<7 | h1<<6 | h2<<5 | h3<<4.
- R6: A hit in a different column than the open frame first emits the open frame and then starts a new one.
- R7: An end-of-event hit leaves no frame open. When it also closes an older frame, the older frame leaves first and the new one follows, and hit_ready is low for the cycle after that hit.
- R8: A change of cfg_mode during an event has no effect until the first hit of the next event.
- R9: While out_valid is high and out_ready is low, out_data and out_kind hold and hit_ready is low.
- R10: out_kind equals the format code of the frame on out_data, and the two lowest bits of every frame are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Frame format code, taken at the first hit of an event |
| hit_valid | input | 1 | Hit present |
| hit_ready | output | 1 | Hit accepted this cycle when high together with hit_valid |
| hit_col | input | 7 | Column address |
| hit_row | input | 9 | Row address |
| hit_tot | input | 4 | Time-over-threshold value |
| hit_last | input | 1 | Final hit of the event |
| out_valid | output | 1 | Frame present |
| out_ready | input | 1 | Downstream accepts the frame |
| out_data | output | 26 | Frame, right-aligned |
| out_kind | output | 2 | Format code of the frame |

## Verification
The hardest case to reach is an end-of-event hit that also closes an older frame: the block must emit two frames back to back while output backpressure is active. Random events with short row gaps, several columns per event and repeated columns make this common. During that phase out_ready is driven by a random stall pattern. Mid-event changes of cfg_mode are driven on purpose to show that the format is held until the next event.

// File: rtl/cff_pkg.sv
package cff_pkg;
  localparam int FRAME_SLOTS = 4;
  localparam int SPAN_W = 3;

  typedef enum logic [1:0] {
    FMT_SINGLE   = 2'd0,
    FMT_PAIR_TOT = 2'd1,
    FMT_PAIR_BIN = 2'd2,
    FMT_QUAD_BIN = 2'd3
  } fmt_e;

  function automatic logic [SPAN_W-1:0] span_of(fmt_e f);
    case (f)
      FMT_SINGLE:   span_of = SPAN_W'(1);
      FMT_QUAD_BIN: span_of = SPAN_W'(4);
      default:      span_of = SPAN_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/hitfmt_merge.sv
module hitfmt_merge
  import cff_pkg::*;
#(
  parameter int COL_W = 7,
  parameter int ROW_W = 9,
  parameter int TOT_W = 4
) (
  input  logic                               f_open,
  input  logic [COL_W-1:0]                   f_col,
  input  logic [ROW_W-1:0]                   f_row,
  input  logic [FRAME_SLOTS-1:0]             f_mask,
  input  logic [FRAME_SLOTS-1:0][TOT_W-1:0]  f_tot,
  input  logic [SPAN_W-1:0]                  span,
  input  logic [COL_W-1:0]                   h_col,
  input  logic [ROW_W-1:0]                   h_row,
  input  logic [TOT_W-1:0]                   h_tot,
  output logic                               merge,
  output logic [COL_W-1:0]                   n_col,
  output logic [ROW_W-1:0]                   n_row,
  output logic [FRAME_SLOTS-1:0]             n_mask,
  output logic [FRAME_SLOTS-1:0][TOT_W-1:0]  n_tot
);
  logic [ROW_W-1:0] diff;
  logic [ROW_W-1:0] span_ext;

  assign diff     = h_row - f_row;
  assign span_ext = {{(ROW_W-SPAN_W){1'b0}}, span};
  assign merge    = f_open && (h_col == f_col) && (h_row > f_row) && (diff < span_ext);
  assign n_col    = merge ? f_col : h_col;
  assign n_row    = merge ? f_row : h_row;

  for (genvar i = 0; i < FRAME_SLOTS; i++) begin : g_slot
    logic here;
    assign here = (diff == ROW_W'(i));
    if (i == 0) begin : g_first
      assign n_mask[i] = merge ? f_mask[i] : 1'b1;
      assign n_tot[i]  = merge ? f_tot[i]  : h_tot;
    end else begin : g_rest
      assign n_mask[i] = merge ? (f_mask[i] | here) : 1'b0;
      assign n_tot[i]  = (merge && here) ? h_tot : f_tot[i];
    end
  end
endmodule

// File: rtl/hitfmt_pack.sv
module hitfmt_pack
  import cff_pkg::*;
#(
  parameter int COL_W = 7,
  parameter int ROW_W = 9,
  parameter int TOT_W = 4,
  parameter logic [TOT_W-1:0] NOHIT = '1,
  parameter int OUT_W = COL_W + ROW_W + 2*TOT_W + 2
) (
  input  fmt_e                               kind,
  input  logic [COL_W-1:0]                   col,
  input  logic [ROW_W-1:0]                   row,
  input  logic [FRAME_SLOTS-1:0]             mask,
  input  logic [FRAME_SLOTS-1:0][TOT_W-1:0]  tot,
  output logic [OUT_W-1:0]                   word
);
  logic [TOT_W-1:0]       slot0_tot, slot1_tot;
  logic [FRAME_SLOTS-1:0] flags_msb_first;

  assign slot0_tot = mask[0] ? tot[0] : NOHIT;
  assign slot1_tot = mask[1] ? tot[1] : NOHIT;

  for (genvar i = 0; i < FRAME_SLOTS; i++) begin : g_rev
    assign flags_msb_first[FRAME_SLOTS-1-i] = mask[i];
  end

  always_comb begin
    case (kind)
      FMT_SINGLE:   word = OUT_W'({col, row, slot0_tot, 2'b00});
      FMT_PAIR_TOT: word = OUT_W'({col, row, slot0_tot, slot1_tot, 2'b00});
      FMT_PAIR_BIN: word = OUT_W'({col, row, mask[0], mask[1], 2'b00});
      FMT_QUAD_BIN: word = OUT_W'({col, row, flags_msb_first, 4'b0000});
      default:      word = '0;
    endcase
  end
endmodule

// File: rtl/hitfmt_outreg.sv
module hitfmt_outreg
  import cff_pkg::*;
#(
  parameter int OUT_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] load_data,
  input  fmt_e             load_kind,
  input  logic             out_ready,
  output logic             can_load,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic [1:0]       out_kind
);
  logic valid_q, valid_d;
  logic [OUT_W-1:0] data_q;
  logic [1:0] kind_q;

  assign can_load = !valid_q || out_ready;

  always_comb begin
    valid_d = valid_q;
    if (load)          valid_d = 1'b1;
    else if (can_load) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      data_q <= load_data;
      kind_q <= load_kind;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_kind  = kind_q;
endmodule

// File: rtl/cluster_frame_fmt.sv
module cluster_frame_fmt
  import cff_pkg::*;
#(
  parameter int COL_W = 7,
  parameter int ROW_W = 9,
  parameter int TOT_W = 4,
  parameter logic [TOT_W-1:0] NOHIT = '1,
  parameter int OUT_W = COL_W + ROW_W + 2*TOT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic             hit_valid,
  output logic             hit_ready,
  input  logic [COL_W-1:0] hit_col,
  input  logic [ROW_W-1:0] hit_row,
  input  logic [TOT_W-1:0] hit_tot,
  input  logic             hit_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic [1:0]       out_kind
);
  // reset release synchronised to clk
  logic [1:0] rst_sync;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign run = rst_sync[1];

  // frame under construction
  logic                              f_open_q, f_open_d;
  logic                              f_pend_q, f_pend_d;
  fmt_e                              f_kind_q;
  logic [COL_W-1:0]                  f_col_q;
  logic [ROW_W-1:0]                  f_row_q;
  logic [FRAME_SLOTS-1:0]            f_mask_q;
  logic [FRAME_SLOTS-1:0][TOT_W-1:0] f_tot_q;
  logic                              frame_we;

  // event tracking
  logic in_ev_q, in_ev_d;
  fmt_e mode_q;
  logic mode_we;
  fmt_e mode_eff;

  // merge results
  logic                              merge;
  logic [COL_W-1:0]                  n_col;
  logic [ROW_W-1:0]                  n_row;
  logic [FRAME_SLOTS-1:0]            n_mask;
  logic [FRAME_SLOTS-1:0][TOT_W-1:0] n_tot;

  logic [OUT_W-1:0] old_word, new_word;
  logic             can_load, accept, breaks_old, emit_old, emit_new, load;
  logic [OUT_W-1:0] load_data;
  fmt_e             load_kind;

  assign mode_eff  = in_ev_q ? mode_q : fmt_e'(cfg_mode);
  assign hit_ready = run && can_load && !f_pend_q;
  assign accept    = hit_valid && hit_ready;

  hitfmt_merge #(.COL_W(COL_W), .ROW_W(ROW_W), .TOT_W(TOT_W)) u_merge (
    .f_open (f_open_q),
    .f_col  (f_col_q),
    .f_row  (f_row_q),
    .f_mask (f_mask_q),
    .f_tot  (f_tot_q),
    .span   (span_of(mode_eff)),
    .h_col  (hit_col),
    .h_row  (hit_row),
    .h_tot  (hit_tot),
    .merge  (merge),
    .n_col  (n_col),
    .n_row  (n_row),
    .n_mask (n_mask),
    .n_tot  (n_tot)
  );

  hitfmt_pack #(.COL_W(COL_W), .ROW_W(ROW_W), .TOT_W(TOT_W), .NOHIT(NOHIT), .OUT_W(OUT_W)) u_pack_old (
    .kind (f_kind_q),
    .col  (f_col_q),
    .row  (f_row_q),
    .mask (f_mask_q),
    .tot  (f_tot_q),
    .word (old_word)
  );

  hitfmt_pack #(.COL_W(COL_W), .ROW_W(ROW_W), .TOT_W(TOT_W), .NOHIT(NOHIT), .OUT_W(OUT_W)) u_pack_new (
    .kind (mode_eff),
    .col  (n_col),
    .row  (n_row),
    .mask (n_mask),
    .tot  (n_tot),
    .word (new_word)
  );

  // emission decisions
  always_comb begin
    breaks_old = accept && f_open_q && !merge;
    emit_old   = run && can_load && (f_pend_q || breaks_old);
    emit_new   = accept && !breaks_old && (hit_last || mode_eff == FMT_SINGLE);
    load       = emit_old || emit_new;
    load_data  = emit_old ? old_word : new_word;
    load_kind  = emit_old ? f_kind_q : mode_eff;
  end

  // next state of frame and event
  always_comb begin
    f_open_d = f_open_q;
    f_pend_d = f_pend_q;
    frame_we = 1'b0;
    in_ev_d  = in_ev_q;
    mode_we  = 1'b0;
    if (f_pend_q && run && can_load) begin
      f_open_d = 1'b0;
      f_pend_d = 1'b0;
    end else if (accept) begin
      in_ev_d = !hit_last;
      mode_we = !in_ev_q;
      if (emit_new) begin
        f_open_d = 1'b0;
      end else begin
        f_open_d = 1'b1;
        frame_we = 1'b1;
        f_pend_d = breaks_old && (hit_last || mode_eff == FMT_SINGLE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_open_q <= 1'b0;
      f_pend_q <= 1'b0;
      in_ev_q  <= 1'b0;
      mode_q   <= FMT_SINGLE;
    end else begin
      f_open_q <= f_open_d;
      f_pend_q <= f_pend_d;
      in_ev_q  <= in_ev_d;
      if (mode_we) mode_q <= fmt_e'(cfg_mode);
    end
  end

  always_ff @(posedge clk) begin
    if (frame_we) begin
      f_kind_q <= mode_eff;
      f_col_q  <= n_col;
      f_row_q  <= n_row;
      f_mask_q <= n_mask;
      f_tot_q  <= n_tot;
    end
  end

  hitfmt_outreg #(.OUT_W(OUT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .load_kind (load_kind),
    .out_ready (out_ready),
    .can_load  (can_load),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_kind  (out_kind)
  );
endmodule

// File: rtl/cff_checker.sv
module cff_checker #(
  parameter int OUT_W = 26,
  parameter int W_SINGLE = 22,
  parameter int W_PAIR_BIN = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hit_valid,
  input logic             hit_ready,
  input logic             hit_last,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic [1:0]       out_kind
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_kind)); // R9

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !hit_ready); // R9

  AST_LAST_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && hit_ready && hit_last |=> out_valid); // R7

  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[1:0] == 2'b00); // R10

  AST_SINGLE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd0 |-> out_data[OUT_W-1:W_SINGLE] == '0); // R2

  AST_PAIR_BIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd2 |-> out_data[OUT_W-1:W_PAIR_BIN] == '0); // R4
endmodule

bind cluster_frame_fmt cff_checker #(
  .OUT_W      (OUT_W),
  .W_SINGLE   (COL_W + ROW_W + TOT_W + 2),
  .W_PAIR_BIN (COL_W + ROW_W + 4)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hit_valid (hit_valid),
  .hit_ready (hit_ready),
  .hit_last  (hit_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_kind  (out_kind)
);

// File: tb/cluster_frame_fmt_bench.sv
module cluster_frame_fmt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        hit_valid = 1'b0;
  logic        hit_ready;
  logic [6:0]  hit_col = '0;
  logic [8:0]  hit_row = '0;
  logic [3:0]  hit_tot = '0;
  logic        hit_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [25:0] out_data;
  logic [1:0]  out_kind;

  always #5 clk = ~clk;

  cluster_frame_fmt u_cluster_frame_fmt (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_col(hit_col),
    .hit_row(hit_row), .hit_tot(hit_tot), .hit_last(hit_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_kind(out_kind)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit stall_en = 1'b0;

  // reference model state
  logic [27:0] expq[$];
  bit m_open = 0;
  bit m_in_ev = 0;
  int m_mode_q = 0;
  int m_kind, m_col, m_row;
  int m_mask[4];
  int m_tot[4];

  function automatic logic [27:0] pack_ref(int k, int c, int r, int mk[4], int t[4]);
    int t0, t1;
    logic [25:0] w;
    t0 = mk[0] ? t[0] : 15;
    t1 = mk[1] ? t[1] : 15;
    case (k)
      0: w = 26'((c << 15) | (r << 6) | (t0 << 2));
      1: w = 26'((c << 19) | (r << 10) | (t0 << 6) | (t1 << 2));
      2: w = 26'((c << 13) | (r << 4) | (mk[0] << 3) | (mk[1] << 2));
      default: w = 26'((c << 17) | (r << 8) | (mk[0] << 7) | (mk[1] << 6) | (mk[2] << 5) | (mk[3] << 4));
    endcase
    return {2'(k), w};
  endfunction

  task automatic model_push();
    expq.push_back(pack_ref(m_kind, m_col, m_row, m_mask, m_tot));
    m_open = 0;
  endtask

  task automatic model_hit(int c, int r, int t, bit last);
    int md, span;
    md = m_in_ev ? m_mode_q : int'(cfg_mode);
    if (!m_in_ev) m_mode_q = int'(cfg_mode);
    m_in_ev = !last;
    span = (md == 0) ? 1 : (md == 3) ? 4 : 2;
    if (m_open && c == m_col && r > m_row && (r - m_row) < span) begin
      m_mask[r - m_row] = 1;
      m_tot[r - m_row] = t;
      if (last) model_push();
    end else begin
      if (m_open) model_push();
      m_open = 1; m_kind = md; m_col = c; m_row = r;
      for (int i = 0; i < 4; i++) begin m_mask[i] = 0; m_tot[i] = 0; end
      m_mask[0] = 1; m_tot[0] = t;
      if (last || md == 0) model_push();
    end
  endtask

  // monitor, sampled at the falling edge
  bit prev_stall = 0;
  logic [27:0] prev_out;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!out_valid || {out_kind, out_data} != prev_out) begin
          errors++;
          $display("FAIL R9 hold: actual %0d/%h expected 1/%h", out_valid, {out_kind, out_data}, prev_out);
        end
      end
      if (out_valid && !out_ready) begin
        checks++;
        if (hit_ready) begin
          errors++;
          $display("FAIL R9 hit_ready during stall: actual 1 expected 0");
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_out = {out_kind, out_data};
      if (hit_valid && hit_ready) model_hit(int'(hit_col), int'(hit_row), int'(hit_tot), hit_last);
      if (out_valid && out_ready) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected frame: actual %h expected none", cur_req, {out_kind, out_data});
        end else begin
          logic [27:0] e;
          e = expq.pop_front();
          if ({out_kind, out_data} != e) begin
            errors++;
            $display("FAIL %s frame: actual %h expected %h", cur_req, {out_kind, out_data}, e);
          end
        end
      end
    end
  end

  // output backpressure
  always @(posedge clk) begin
    #1 out_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  task automatic send(int c, int r, int t, bit last);
    hit_valid = 1'b1;
    hit_col = 7'(c); hit_row = 9'(r); hit_tot = 4'(t); hit_last = last;
    do @(negedge clk); while (!hit_ready);
    @(posedge clk); #1;
    hit_valid = 1'b0; hit_last = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && (expq.size() != 0 || out_valid); i++) @(posedge clk);
    @(posedge clk); #1;
  endtask

  task automatic check_empty(string req);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s pending frames: actual %0d expected 0", req, expq.size());
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || hit_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset state: actual valid=%b ready=%b expected valid=0 ready=1", out_valid, hit_ready);
    end
    @(posedge clk); #1;

    cur_req = "R2"; cfg_mode = 2'd0;
    send(3, 5, 7, 0); send(3, 6, 2, 0); send(10, 335, 14, 1);
    drain(); check_empty("R2");

    cur_req = "R3"; cfg_mode = 2'd1;
    send(4, 8, 1, 0); send(4, 9, 2, 0); send(4, 11, 3, 0); send(4, 12, 4, 1);
    send(79, 0, 5, 1);
    send(4, 20, 6, 0); send(4, 22, 7, 1);
    drain(); check_empty("R3");

    cur_req = "R4"; cfg_mode = 2'd2;
    send(2, 100, 1, 0); send(2, 101, 1, 0); send(2, 103, 1, 1);
    drain(); check_empty("R4");

    cur_req = "R5"; cfg_mode = 2'd3;
    send(6, 10, 0, 0); send(6, 11, 0, 0); send(6, 13, 0, 0); send(6, 14, 0, 1);
    send(6, 40, 0, 0); send(6, 43, 0, 1);
    drain(); check_empty("R5");

    cur_req = "R6"; cfg_mode = 2'd1;
    send(1, 7, 9, 0); send(2, 8, 10, 1);
    cfg_mode = 2'd3;
    send(1, 7, 0, 0); send(2, 8, 0, 0); send(2, 9, 0, 1);
    drain(); check_empty("R6");

    cur_req = "R7"; cfg_mode = 2'd1;
    send(5, 10, 3, 0); send(5, 20, 4, 1);
    @(negedge clk);
    checks++;
    if (hit_ready !== 1'b0) begin
      errors++;
      $display("FAIL R7 hit_ready after double flush: actual %b expected 0", hit_ready);
    end
    drain(); check_empty("R7");

    cur_req = "R8"; cfg_mode = 2'd1;
    send(1, 0, 2, 0);
    cfg_mode = 2'd0;
    send(1, 1, 3, 1);
    send(1, 4, 8, 1);
    cfg_mode = 2'd3;
    send(9, 50, 0, 0);
    cfg_mode = 2'd2;
    send(9, 53, 0, 1);
    drain(); check_empty("R8");

    cur_req = "R10"; stall_en = 1'b1;
    for (int ev = 0; ev < 300; ev++) begin
      int ncols;
      cfg_mode = 2'($urandom_range(0, 3));
      ncols = $urandom_range(1, 3);
      for (int ci = 0; ci < ncols; ci++) begin
        int c, r, nh;
        c = $urandom_range(0, 79);
        r = $urandom_range(0, 300);
        nh = $urandom_range(1, 5);
        for (int h = 0; h < nh; h++) begin
          send(c, r, $urandom_range(0, 14), (ci == ncols - 1) && (h == nh - 1));
          if ($urandom_range(0, 3) == 0) cfg_mode = 2'($urandom_range(0, 3));
          r = r + $urandom_range(1, 3);
        end
      end
    end
    stall_en = 1'b0;
    drain(); check_empty("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule